// File: doc/BRIEF.md
# Dual-Half Sector Hamming ECC Engine

This block generates the Hamming check code for a 512-byte flash sector while the sector's bytes move through the controller's 16-bit data port. The sector is split into two 256-byte halves, and each half has its own single-error-correcting code. A code has 16 line-parity bits, taken from the byte index, and 6 column-parity bits, taken from the bit position within a byte. Each half can therefore locate one flipped bit, so the sector can correct up to two.

Software steers the engine by writing a mode code. One code clears the engine. The data access that follows a clear is a dummy and is discarded. A second code makes every following data access feed its bytes into the parity. A third code turns the data port into a readout of the six code bytes, packed into three interleaved 16-bit words. Parity is held inverted, so a fully erased sector reads back as all-ones code bytes.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset the engine is idle, `result_o` is 0x0000, the byte count is zero, and a readout without any data returns 0xFFFF for all three words.
- R2: Writing mode 0xF4 clears both half-codes and the byte count. Data accesses made while that mode is active (the dummy access) change nothing.
- R3: In mode 0xB4 each data access adds one byte (`two_i`=0, taken from `data_i[7:0]`) or two bytes (`two_i`=1, with `data_i[7:0]` as the earlier byte and `data_i[15:8]` as the later one) at consecutive sector positions.
- R4: Line parity bit 2k+1 (k=0..7) is the XOR over the half's bytes whose in-half index has bit k set, and bit 2k is the XOR over those whose bit k is clear. Here "XOR" means the XOR of all eight bits of each byte.
- R5: Column parity bit 2k+1 (k=0..2) is the XOR of every data bit whose bit position within its byte has bit k set, and bit 2k covers the positions with bit k clear. The column byte holds CP5..CP0 in bits 7:2, and bits 1:0 are always 1.
- R6: All parity is reported inverted. A half with no bytes, or with only 0x00 bytes or only 0xFF bytes, yields 0xFF in every one of its code bytes.
- R7: Sector positions 0..255 feed the first half-code and positions 256..511 feed the second. A two-byte access may split across the two halves.
- R8: Bytes past position 511 are discarded until the next clear. A two-byte access that reaches past the end keeps only its low byte.
- R9: In mode 0xD4, `result_o` shows three words in turn, and each data access advances to the next. Word 0 is {half0 LP15..8, half0 LP7..0}, word 1 is {half1 LP7..0, half0 column byte}, and word 2 is {half1 column byte, half1 LP15..8}, each given as {bits 15:8, bits 7:0}. After word 2 the readout wraps to word 0, and every write of 0xD4 restarts at word 0.
- R10: Any other mode code makes the engine idle. In that state data accesses change neither code, and `result_o` is 0x0000 in every mode except 0xD4. A mode write wins over a data access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 8 | Mode code written |
| acc_i | input | 1 | Data port access strobe |
| two_i | input | 1 | Access carries two bytes |
| data_i | input | 16 | Data port bytes, earlier byte in bits 7:0 |
| result_o | output | 16 | Readout word in mode 0xD4, otherwise zero |

## Verification
The hardest case to reach is the sector's end, where a two-byte access lands on position 511. There the low byte must be kept and the high byte dropped. The bench reaches it by clearing the engine and feeding 255 words and then one single byte, so that the next two-byte access straddles the limit. The boundary between the halves is reached by placing a lone set bit just past position 256, which must appear only in the second half-code. A behavioural model keeps the accepted bytes in a queue, recomputes both codes on every clock, and predicts the readout word.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam logic [7:0] MODE_CLEAR = 8'hF4;
  localparam logic [7:0] MODE_CALC  = 8'hB4;
  localparam logic [7:0] MODE_READ  = 8'hD4;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_CLEAR = 2'd1,
    ENG_CALC  = 2'd2,
    ENG_READ  = 2'd3
  } eng_state_e;

  localparam int unsigned RD_WORDS = 3;
endpackage

// File: rtl/nand_ecc_ctl.sv
module nand_ecc_ctl
  import nand_ecc_pkg::*;
#(
  parameter int unsigned SECTOR = 512,
  localparam int unsigned CNT_W = $clog2(SECTOR + 1),
  localparam int unsigned POS_W = $clog2(SECTOR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic [7:0]       mode_i,
  input  logic             acc_i,
  input  logic             two_i,
  output eng_state_e       state_o,
  output logic             clear_o,
  output logic [1:0]       lane_en_o,
  output logic [POS_W-1:0] pos0_o,
  output logic [POS_W-1:0] pos1_o,
  output logic [1:0]       rd_ptr_o
);
  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   pos1_w;
  logic [1:0]       ptr_q, ptr_d;
  logic             take;

  assign take    = acc_i && !mode_we_i;
  assign clear_o = mode_we_i && (mode_i == MODE_CLEAR);
  assign pos1_w  = {1'b0, cnt_q} + (CNT_W+1)'(1);

  assign lane_en_o[0] = take && (state_q == ENG_CALC) && (cnt_q < CNT_W'(SECTOR));
  assign lane_en_o[1] = take && two_i && (state_q == ENG_CALC) && (pos1_w < (CNT_W+1)'(SECTOR));
  assign pos0_o = cnt_q[POS_W-1:0];
  assign pos1_o = pos1_w[POS_W-1:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(lane_en_o[0]) + CNT_W'(lane_en_o[1]);
    ptr_d   = ptr_q;
    if (mode_we_i) begin
      unique case (mode_i)
        MODE_CLEAR: begin state_d = ENG_CLEAR; cnt_d = '0; end
        MODE_CALC:  state_d = ENG_CALC;
        MODE_READ:  begin state_d = ENG_READ; ptr_d = '0; end
        default:    state_d = ENG_IDLE;
      endcase
    end else if (take && state_q == ENG_READ) begin
      ptr_d = (ptr_q == 2'(RD_WORDS - 1)) ? 2'd0 : ptr_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
    end
  end

  assign state_o  = state_q;
  assign rd_ptr_o = ptr_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SECTOR)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_i == MODE_CLEAR) |=> (cnt_q == '0)); // R2
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < 2'(RD_WORDS)); // R9
  AST_READ_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_i == MODE_READ) |=> (ptr_q == 2'd0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ENG_CALC && !mode_we_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/nand_ecc_half.sv
module nand_ecc_half #(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned LP_W = 2 * IDX_W,
  localparam int unsigned CP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [1:0]       lane_en_i,
  input  logic [IDX_W-1:0] idx0_i,
  input  logic [IDX_W-1:0] idx1_i,
  input  logic [7:0]       byte0_i,
  input  logic [7:0]       byte1_i,
  output logic [LP_W-1:0]  lp_o,
  output logic [7:0]       cp_o
);
  logic [LP_W-1:0] lp_q;
  logic [CP_W-1:0] cp_q;

  function automatic logic [LP_W+CP_W-1:0] contrib(input logic [IDX_W-1:0] idx,
                                                   input logic [7:0] b);
    logic [LP_W-1:0] lp;
    logic [CP_W-1:0] cp;
    logic            row;
    row = ^b;
    for (int k = 0; k < IDX_W; k++) begin
      lp[2*k+1] = row & idx[k];
      lp[2*k]   = row & ~idx[k];
    end
    cp = '0;
    for (int k = 0; k < 3; k++)
      for (int p = 0; p < 8; p++)
        if (((p >> k) & 1) == 1) cp[2*k+1] = cp[2*k+1] ^ b[p];
        else                     cp[2*k]   = cp[2*k]   ^ b[p];
    return {lp, cp};
  endfunction

  logic [LP_W+CP_W-1:0] c0, c1, sum;
  always_comb begin
    c0  = lane_en_i[0] ? contrib(idx0_i, byte0_i) : '0;
    c1  = lane_en_i[1] ? contrib(idx1_i, byte1_i) : '0;
    sum = c0 ^ c1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clear_i) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (|lane_en_i) begin
      lp_q <= lp_q ^ sum[LP_W+CP_W-1:CP_W];
      cp_q <= cp_q ^ sum[CP_W-1:0];
    end
  end

  // inverted storage: erased data gives all-ones code
  assign lp_o = ~lp_q;
  assign cp_o = {~cp_q, 2'b11};

  AST_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_en_i == 2'b00 && !clear_i) |=> ($stable(lp_q) && $stable(cp_q))); // R10
  AST_HALF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (lp_o == '1 && cp_o == 8'hFF)); // R2
endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout (
  input  logic        en_i,
  input  logic [1:0]  ptr_i,
  input  logic [15:0] lp0_i,
  input  logic [7:0]  cp0_i,
  input  logic [15:0] lp1_i,
  input  logic [7:0]  cp1_i,
  output logic [15:0] word_o
);
  always_comb begin
    word_o = '0;
    if (en_i) begin
      unique case (ptr_i)
        2'd0:    word_o = {lp0_i[15:8], lp0_i[7:0]};
        2'd1:    word_o = {lp1_i[7:0], cp0_i};
        2'd2:    word_o = {cp1_i, lp1_i[15:8]};
        default: word_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned HALF_BYTES = SECTOR_BYTES / 2,
  localparam int unsigned IDX_W = $clog2(HALF_BYTES),
  localparam int unsigned POS_W = $clog2(SECTOR_BYTES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_we_i,
  input  logic [7:0]  mode_i,
  input  logic        acc_i,
  input  logic        two_i,
  input  logic [15:0] data_i,
  output logic [15:0] result_o
);
  eng_state_e       state;
  logic             clear;
  logic [1:0]       lane_en;
  logic [POS_W-1:0] pos0, pos1;
  logic [1:0]       rd_ptr;
  logic [15:0]      lp   [2];
  logic [7:0]       cp   [2];

  nand_ecc_ctl #(.SECTOR(SECTOR_BYTES)) u_ctl (
    .clk_i, .rst_ni, .mode_we_i, .mode_i, .acc_i, .two_i,
    .state_o(state), .clear_o(clear), .lane_en_o(lane_en),
    .pos0_o(pos0), .pos1_o(pos1), .rd_ptr_o(rd_ptr)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [1:0] en_h;
    assign en_h[0] = lane_en[0] && (pos0[POS_W-1] == 1'(h));
    assign en_h[1] = lane_en[1] && (pos1[POS_W-1] == 1'(h));
    nand_ecc_half #(.IDX_W(IDX_W)) u_half (
      .clk_i, .rst_ni, .clear_i(clear), .lane_en_i(en_h),
      .idx0_i(pos0[IDX_W-1:0]), .idx1_i(pos1[IDX_W-1:0]),
      .byte0_i(data_i[7:0]), .byte1_i(data_i[15:8]),
      .lp_o(lp[h]), .cp_o(cp[h])
    );
  end

  nand_ecc_readout u_rd (
    .en_i(state == ENG_READ), .ptr_i(rd_ptr),
    .lp0_i(lp[0]), .cp0_i(cp[0]), .lp1_i(lp[1]), .cp1_i(cp[1]),
    .word_o(result_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_i != MODE_READ) |=> (result_o == 16'h0000)); // R10
  AST_SPLIT_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_en[1] && !lane_en[0]) |-> 1'b0); // R8
endmodule

// File: tb/nand_ecc_engine_bench.sv
module nand_ecc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode = 8'h00;
  logic        acc = 1'b0;
  logic        two = 1'b0;
  logic [15:0] data = 16'h0000;
  logic [15:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  nand_ecc_engine u_nand_ecc_engine (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode),
    .acc_i(acc), .two_i(two), .data_i(data), .result_o(result)
  );

  // reference model: 0 idle, 1 clear, 2 calc, 3 read
  logic [7:0] q[$];
  int m_state = 0;
  int m_ptr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_state = 0; m_ptr = 0;
    end else if (mode_we) begin
      if (mode == 8'hF4) begin q.delete(); m_state = 1; end
      else if (mode == 8'hB4) m_state = 2;
      else if (mode == 8'hD4) begin m_state = 3; m_ptr = 0; end
      else m_state = 0;
    end else if (acc) begin
      if (m_state == 2) begin
        if (q.size() < 512) q.push_back(data[7:0]);
        if (two && q.size() < 512) q.push_back(data[15:8]);
      end else if (m_state == 3) begin
        m_ptr = (m_ptr + 1) % 3;
      end
    end
  end

  function automatic logic [15:0] m_lp(int h);
    logic [15:0] a = '0;
    for (int j = 0; j < 16; j++)
      for (int i = 0; i < 256; i++)
        if (h*256 + i < q.size() && ((i >> (j/2)) & 1) == (j % 2))
          a[j] = a[j] ^ (^q[h*256 + i]);
    return ~a;
  endfunction

  function automatic logic [7:0] m_cp(int h);
    logic [5:0] a = '0;
    for (int i = 0; i < 256; i++)
      if (h*256 + i < q.size())
        for (int j = 0; j < 6; j++)
          for (int p = 0; p < 8; p++)
            if (((p >> (j/2)) & 1) == (j % 2)) a[j] = a[j] ^ q[h*256 + i][p];
    return {~a, 2'b11};
  endfunction

  function automatic logic [15:0] m_word();
    logic [15:0] l0, l1;
    if (m_state != 3) return 16'h0000;
    l0 = m_lp(0); l1 = m_lp(1);
    case (m_ptr)
      0: return l0;
      1: return {l1[7:0], m_cp(0)};
      default: return {m_cp(1), l1[15:8]};
    endcase
  endfunction

  // per-cycle comparison against the model (R3..R10)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] e;
      cycles++;
      if (m_state == 3 || result != 16'h0000) begin
        e = m_word();
        checks++;
        if (result !== e) begin
          fails++;
          $display("FAIL R9 model compare cycle %0d: got %h exp %h", cycles, result, e);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R1 watchdog expired: got hang exp finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic set_mode(logic [7:0] m);
    @(negedge clk); mode_we = 1'b1; mode = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic put(logic [15:0] w, logic t);
    @(negedge clk); acc = 1'b1; two = t; data = w;
    @(negedge clk); acc = 1'b0; two = 1'b0;
  endtask

  task automatic rd(string tag, logic [15:0] exp);
    @(negedge clk);
    chk(tag, result, exp);
    acc = 1'b1;
    @(negedge clk); acc = 1'b0;
  endtask

  task automatic read3(string tag, logic [15:0] e0, logic [15:0] e1, logic [15:0] e2);
    set_mode(8'hD4);
    rd(tag, e0); rd(tag, e1); rd(tag, e2);
  endtask

  task automatic start();
    set_mode(8'hF4);
    put(16'h0101, 1'b1); // dummy access
    set_mode(8'hB4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", result, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle result", result, 16'h0000);
    read3("R1 empty readout", 16'hFFFF, 16'hFFFF, 16'hFFFF);

    // R4 R5 R2: single set bit at index 5 of half 0, after a dummy access
    start();
    for (int w = 0; w < 128; w++) put((w == 2) ? 16'h0100 : 16'h0000, 1'b1);
    read3("R4 R5 half0 bit", 16'hAA99, 16'hFFAB, 16'hFFFF);
    rd("R9 wrap to word0", 16'hAA99);
    rd("R9 word1 again", 16'hFFAB);
    set_mode(8'hD4);
    rd("R9 restart at word0", 16'hAA99);

    // R3 byte order within a two-byte access
    start();
    put(16'h0100, 1'b1);
    read3("R3 two-byte order", 16'hAAA9, 16'hFFAB, 16'hFFFF);
    start();
    put(16'h0000, 1'b0);
    put(16'h0001, 1'b0);
    read3("R3 single-byte access", 16'hAAA9, 16'hFFAB, 16'hFFFF);

    // R7 bit just past the half boundary lands in half 1
    start();
    for (int w = 0; w < 131; w++) put((w == 130) ? 16'h0100 : 16'h0000, 1'b1);
    read3("R7 half1 bit", 16'hFFFF, 16'h99FF, 16'hABAA);

    // R6 erased sector
    start();
    for (int w = 0; w < 256; w++) put(16'hFFFF, 1'b1);
    read3("R6 erased sector", 16'hFFFF, 16'hFFFF, 16'hFFFF);

    // R8 bytes beyond the sector, including a straddling two-byte access
    start();
    for (int w = 0; w < 255; w++) put(16'h0000, 1'b1);
    put(16'h0000, 1'b0);
    put(16'h0100, 1'b1);
    put(16'hFFFF, 1'b1);
    put(16'h0001, 1'b0);
    read3("R8 past end ignored", 16'hFFFF, 16'hFFFF, 16'hFFFF);

    // R10 other mode: accesses ignored, result zero
    start();
    put(16'h0000, 1'b1); put(16'h0000, 1'b1); put(16'h0100, 1'b1);
    set_mode(8'h94);
    @(negedge clk);
    chk("R10 idle result zero", result, 16'h0000);
    put(16'h0001, 1'b1);
    set_mode(8'hF4);
    @(negedge clk);
    chk("R10 clear mode result zero", result, 16'h0000);
    set_mode(8'hB4);
    put(16'h0100, 1'b1);
    set_mode(8'h94);
    put(16'h8000, 1'b1);
    read3("R10 ignored while idle", 16'hAAA9, 16'hFFAB, 16'hFFFF);

    // R2 clear wipes a previous code
    set_mode(8'hF4);
    read3("R2 cleared code", 16'hFFFF, 16'hFFFF, 16'hFFFF);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule